// File: doc/BRIEF.md
# Watch-Crystal Real-Time Clock Counter

This block keeps time of day from a 32.768 kHz tick enable. A 16-bit tick counter advances once per tick. Each time it overflows, it forces its top bit back to one and lets every lower bit keep counting. The result is an overflow once every 32768 ticks, which is exactly one second. The lower bits are never preloaded, so the one-second period does not drift however the ticks are spaced.

Each overflow produces a one-cycle second pulse and advances a seconds counter. The seconds counter carries into a minutes counter, and the minutes counter carries into an hours counter. A synchronous set strobe loads a new time of day and restarts the current second. A run enable freezes the tick counter and everything fed from it.

Top module: `wc_rtc`

## Requirements
- R1: While rst_ni is low, and after its release, hr_o, min_o and sec_o are 0 and sec_pulse_o is 0. The tick counter starts at 0x8000, so the first second after reset lasts 32768 ticks.
- R2: The tick counter advances only in a cycle where run_i and tick_i are both 1. With run_i at 0, ticks have no effect on the time or the pulse.
- R3: When the counter overflows from 0xFFFF, bit 15 is set and bits 14..0 continue from the incremented value and are not reloaded. Consecutive overflows are therefore exactly 32768 counted ticks apart, whatever the gaps between ticks.
- R4: sec_pulse_o is high for exactly one clock cycle. That cycle directly follows the clock edge that counted the overflowing tick.
- R5: Each overflow increments sec_o by one, on the same edge that raises sec_pulse_o. sec_o counts from 0 to 59 and then wraps to 0.
- R6: min_o increments when sec_o wraps from 59 to 0. It counts from 0 to 59 and then wraps.
- R7: hr_o increments when min_o wraps from 59 to 0. It counts from 0 to 23 and then wraps, so 23:59:59 is followed by 00:00:00.
- R8: A cycle with set_i at 1 loads set_hr_i, set_min_i and set_sec_i and restarts the tick counter at 0x8000. It raises no pulse and takes precedence over a tick in the same cycle. This holds even when that tick would have overflowed the counter, and whatever the value of run_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable |
| tick_i | input | 1 | One-cycle 32.768 kHz tick enable |
| set_i | input | 1 | Time-load strobe |
| set_hr_i | input | 5 | Hours value to load, 0..23 |
| set_min_i | input | 6 | Minutes value to load, 0..59 |
| set_sec_i | input | 6 | Seconds value to load, 0..59 |
| hr_o | output | 5 | Current hours |
| min_o | output | 6 | Current minutes |
| sec_o | output | 6 | Current seconds |
| sec_pulse_o | output | 1 | One-cycle pulse on each tick-counter overflow |

## Verification
The range assertions assume that every value loaded through set_i is a legal time: hours at most 23, minutes and seconds at most 59. The bench draws its random loads only from those ranges, and its directed loads are picked just below each wrap point. The properties also assume that reset is low from time zero. Reaching a single overflow takes 32768 counted ticks, so the bench runs full-rate tick stretches for the carry cases. Its short random windows exercise gaps, run_i low and loads.

// File: rtl/wc_rtc_pkg.sv
package wc_rtc_pkg;
  localparam int SEC_MOD = 60;
  localparam int MIN_MOD = 60;
  localparam int HR_MOD  = 24;
  localparam int SEC_W   = $clog2(SEC_MOD);
  localparam int MIN_W   = $clog2(MIN_MOD);
  localparam int HR_W    = $clog2(HR_MOD);

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } tod_t;
endpackage

// File: rtl/wc_tick_ctr.sv
module wc_tick_ctr #(
  parameter int TICK_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic restart_i,
  output logic ovf_o
);
  localparam logic [TICK_W-1:0] HALF = {1'b1, {(TICK_W-1){1'b0}}};

  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic [TICK_W:0]   inc;

  assign inc   = {1'b0, cnt_q} + 1'b1;
  assign ovf_o = adv_i & ~restart_i & inc[TICK_W];

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = HALF;
    end else if (adv_i) begin
      cnt_d = inc[TICK_W-1:0];
      // only the MSb is forced; low bits run on untouched
      if (inc[TICK_W]) cnt_d[TICK_W-1] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= HALF;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wc_wrap_ctr.sv
module wc_wrap_ctr #(
  parameter int MOD = 60,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] val_q;

  assign wrap_o = inc_i & ~load_i & (val_q >= LAST);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= (val_q >= LAST) ? '0 : val_q + 1'b1;
  end
endmodule

// File: rtl/wc_rtc.sv
module wc_rtc
  import wc_rtc_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             set_i,
  input  logic [HR_W-1:0]  set_hr_i,
  input  logic [MIN_W-1:0] set_min_i,
  input  logic [SEC_W-1:0] set_sec_i,
  output logic [HR_W-1:0]  hr_o,
  output logic [MIN_W-1:0] min_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             sec_pulse_o
);
  logic ovf, sec_wrap, min_wrap, hr_wrap;
  logic pulse_q;
  tod_t ld, cur;

  assign ld = '{hr: set_hr_i, mn: set_min_i, sc: set_sec_i};

  wc_tick_ctr #(.TICK_W(TICK_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (run_i & tick_i),
    .restart_i (set_i),
    .ovf_o     (ovf)
  );

  wc_wrap_ctr #(.MOD(SEC_MOD), .W(SEC_W)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (ovf),
    .load_i     (set_i),
    .load_val_i (ld.sc),
    .val_o      (cur.sc),
    .wrap_o     (sec_wrap)
  );

  wc_wrap_ctr #(.MOD(MIN_MOD), .W(MIN_W)) u_min (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (sec_wrap),
    .load_i     (set_i),
    .load_val_i (ld.mn),
    .val_o      (cur.mn),
    .wrap_o     (min_wrap)
  );

  wc_wrap_ctr #(.MOD(HR_MOD), .W(HR_W)) u_hr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (min_wrap),
    .load_i     (set_i),
    .load_val_i (ld.hr),
    .val_o      (cur.hr),
    .wrap_o     (hr_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= ovf;
  end

  assign hr_o        = cur.hr;
  assign min_o       = cur.mn;
  assign sec_o       = cur.sc;
  assign sec_pulse_o = pulse_q;

  logic unused_hr_wrap;
  assign unused_hr_wrap = hr_wrap;
endmodule

// File: rtl/wc_rtc_chk.sv
module wc_rtc_chk
  import wc_rtc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             set_i,
  input logic [HR_W-1:0]  set_hr_i,
  input logic [MIN_W-1:0] set_min_i,
  input logic [SEC_W-1:0] set_sec_i,
  input logic [HR_W-1:0]  hr_o,
  input logic [MIN_W-1:0] min_o,
  input logic [SEC_W-1:0] sec_o,
  input logic             sec_pulse_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_idle_chk: assert (sec_pulse_o == 1'b0);
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |=> !sec_pulse_o);

  // R5
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |-> sec_o == (($past(sec_o) == 6'd59) ? 6'd0 : $past(sec_o) + 6'd1));

  // R5
  sec_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sec_o) && !$past(set_i)) |-> sec_pulse_o);

  // R5
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o <= 6'd59);

  // R6
  min_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(min_o) && !$past(set_i)) |-> (sec_pulse_o && sec_o == 6'd0));

  // R6
  min_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_o <= 6'd59);

  // R7
  hr_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(hr_o) && !$past(set_i)) |-> (sec_pulse_o && min_o == 6'd0 && sec_o == 6'd0));

  // R7
  hr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hr_o <= 5'd23);

  // R2
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_i) && !$past(set_i)) |-> (!sec_pulse_o && $stable(sec_o)));

  // R8
  set_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_i) |-> (!sec_pulse_o && sec_o == $past(set_sec_i) &&
                      min_o == $past(set_min_i) && hr_o == $past(set_hr_i)));
endmodule

bind wc_rtc wc_rtc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .set_i       (set_i),
  .set_hr_i    (set_hr_i),
  .set_min_i   (set_min_i),
  .set_sec_i   (set_sec_i),
  .hr_o        (hr_o),
  .min_o       (min_o),
  .sec_o       (sec_o),
  .sec_pulse_o (sec_pulse_o)
);

// File: tb/wc_rtc_tb_top.sv
module wc_rtc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_W     = 16;
  localparam int SEC_TICKS  = 1 << (TICK_W - 1);
  localparam int WD_LIMIT   = 190000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, run, tick, set;
  logic [4:0] set_hr, hr;
  logic [5:0] set_min, set_sec, mn, sc;
  logic       pulse;

  wc_rtc #(.TICK_W(TICK_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tick_i(tick), .set_i(set),
    .set_hr_i(set_hr), .set_min_i(set_min), .set_sec_i(set_sec),
    .hr_o(hr), .min_o(mn), .sec_o(sc), .sec_pulse_o(pulse)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;

  // bench model, derived from the requirements
  logic [TICK_W-1:0] m_cnt;
  int m_hr, m_min, m_sec;
  logic m_pulse;

  function automatic int wrap_inc(int v, int modulus);
    return (v >= modulus - 1) ? 0 : v + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare(string ph);
    chk({"R3/R4 pulse ", ph}, int'(pulse), int'(m_pulse));
    chk({"R5 sec ", ph}, int'(sc), m_sec);
    chk({"R6 min ", ph}, int'(mn), m_min);
    chk({"R7 hr ", ph}, int'(hr), m_hr);
  endtask

  task automatic model_step(logic r, logic t, logic s, int h, int m, int c);
    m_pulse = 1'b0;
    if (s) begin
      m_cnt = {1'b1, {(TICK_W-1){1'b0}}};
      m_hr = h; m_min = m; m_sec = c;
    end else if (r && t) begin
      if (m_cnt == '1) begin
        m_cnt = {1'b1, {(TICK_W-1){1'b0}}};
        m_pulse = 1'b1;
        if (m_sec == 59) begin
          if (m_min == 59) m_hr = wrap_inc(m_hr, 24);
          m_min = wrap_inc(m_min, 60);
        end
        m_sec = wrap_inc(m_sec, 60);
      end else begin
        m_cnt = m_cnt + 1'b1;
      end
    end
  endtask

  task automatic cycle(logic r, logic t, logic s, int h, int m, int c, string ph);
    @(negedge clk);
    compare(ph);
    run = r; tick = t; set = s;
    set_hr = 5'(h); set_min = 6'(m); set_sec = 6'(c);
    @(posedge clk);
    #1;
    model_step(r, t, s, h, m, c);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run = 1'b0; tick = 1'b0; set = 1'b0;
    set_hr = '0; set_min = '0; set_sec = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset hr", int'(hr), 0);
    chk("R1 reset min", int'(mn), 0);
    chk("R1 reset sec", int'(sc), 0);
    chk("R1 reset pulse", int'(pulse), 0);
    rst_n = 1'b1;
    m_cnt = {1'b1, {(TICK_W-1){1'b0}}};
    m_hr = 0; m_min = 0; m_sec = 0; m_pulse = 1'b0;

    // R1/R3 first second from reset at full tick rate
    for (int i = 0; i < SEC_TICKS; i++) cycle(1, 1, 0, 0, 0, 0, "R1 first second");
    cycle(1, 0, 0, 0, 0, 0, "R4 pulse edge");
    cycle(1, 0, 0, 0, 0, 0, "R4 pulse drop");

    // R2 run low blocks ticks
    for (int i = 0; i < 40; i++) cycle(0, 1, 0, 0, 0, 0, "R2 run low");

    // R6 minute carry with ticks gapped by random idle cycles
    cycle(1, 1, 1, 10, 59, 59, "R8 load 10:59:59");
    for (int i = 0; i < SEC_TICKS; i++) begin
      cycle(1, 1, 0, 0, 0, 0, "R6 minute carry");
      if (($urandom % 64) == 0) cycle(1, 0, 0, 0, 0, 0, "R3 gap");
    end
    cycle(1, 0, 0, 0, 0, 0, "R6 after carry");

    // R8 load wins over the overflowing tick
    for (int i = 0; i < SEC_TICKS - 1; i++) cycle(1, 1, 0, 0, 0, 0, "R3 near overflow");
    cycle(1, 1, 1, 23, 59, 59, "R8 set vs overflow");
    cycle(1, 0, 0, 0, 0, 0, "R8 no pulse");

    // R7 day rollover 23:59:59 -> 00:00:00
    for (int i = 0; i < SEC_TICKS; i++) cycle(1, 1, 0, 0, 0, 0, "R7 day wrap");
    cycle(1, 0, 0, 0, 0, 0, "R7 after wrap");

    // R8 load while stopped
    cycle(0, 0, 1, 7, 30, 15, "R8 load run low");
    cycle(0, 1, 0, 0, 0, 0, "R8 held");

    // random mix: gapped ticks, run toggling, legal loads
    for (int i = 0; i < 4000; i++) begin
      logic r, t, s;
      r = ($urandom % 10) != 0;
      t = ($urandom % 2) == 0;
      s = ($urandom % 200) == 0;
      cycle(r, t, s, int'($urandom % 24), int'($urandom % 60), int'($urandom % 60), "random");
    end
    cycle(0, 0, 0, 0, 0, 0, "final");
    summary();
  end
endmodule